// File: doc/BRIEF.md
# Row-Locality Migration Predictor

This block belongs to a hybrid memory controller in which a small DRAM serves as a cache for rows of a larger and slower non-volatile memory. The controller reports each non-volatile memory access to the block. A report carries the row identifier and a flag that says whether the access hit the open row buffer or caused a row-buffer conflict. The block keeps a small table of recently seen rows. Each entry holds two saturating counters: one for conflicts, which predicts future locality, and one for total accesses, which predicts reuse. A row is put forward for copying into DRAM only when both counters are strictly above their current thresholds. A row that is only ever streamed through, with few repeat accesses or no conflicts, therefore stays in non-volatile memory. Data moves in whole 4 KB rows, so the request carries only the row identifier.

The block retunes its two thresholds at every interval tick. It compares a cost estimate with a benefit estimate. The cost is the number of migrations issued in the interval multiplied by a programmable per-migration cost. The benefit is the sum, over those migrations, of the migrated rows' conflict counts, multiplied by a programmable gain. If the cost is larger, both thresholds rise by one. Otherwise both fall by one. Both thresholds are held between 1 and a programmable ceiling.

Requests leave through a valid/ready handshake driven by a two-state machine. In state S_IDLE no request is outstanding. When a row qualifies, the transition S_IDLE to S_OFFER is taken. In state S_OFFER the row identifier is held on the output. The transition S_OFFER to S_IDLE is taken at a clock edge where ready is high. While in S_OFFER, including the cycle in which the request is accepted, no new decision is made. Accesses in that time still update the counters.

Top module: `rowloc_promoter`

## Requirements
- R1: After reset no request is offered. The conflict threshold is 2 and the access threshold is 3, so a new row that sees only conflict accesses qualifies on its 4th access.
- R2: On an access with acc_valid high, the row's counters are updated. This applies to conflict (acc_conflict=1) and row hit (acc_conflict=0) accesses alike. If both updated counters then exceed their thresholds and no request is outstanding, mig_valid rises in the next cycle with mig_row equal to the row. The row's entry is then cleared, so later accesses to it count from zero.
- R3: Hit-only accesses never cause a request, however many there are. The conflict counter of such a row stays at zero.
- R4: The table holds ENTRIES rows. A row that is not in the table takes an entry with cleared counters, and the access that brings it in is counted. The entry chosen is the lowest-indexed empty one if any exists; otherwise it is the least recently used one.
- R5: Both counters saturate at 2^CNT_W-1 and do not wrap.
- R6: While mig_valid is high and mig_ready is low, mig_valid stays high and mig_row does not change. No new request is raised while one is outstanding. A row that qualified during that time is requested only on its next access after acceptance.
- R7: On each interval tick both thresholds step up by one when cost exceeds benefit and down by one otherwise. The result is clamped to the range 1 to thr_max, and the new values apply from the next cycle.
- R8: The cost is the interval's migration count times mig_cost. The benefit is the interval's sum of migrated rows' conflict counts times conflict_gain. When the two are equal, the thresholds step down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One non-volatile memory access reported this cycle |
| acc_row | input | ROW_W | Row identifier of the access |
| acc_conflict | input | 1 | 1 = row-buffer conflict, 0 = row-buffer hit |
| interval_tick | input | 1 | End-of-interval pulse that triggers threshold retuning |
| thr_max | input | CNT_W | Ceiling for both thresholds |
| mig_cost | input | COST_W | Estimated cost of one migration |
| conflict_gain | input | GAIN_W | Estimated saving per conflict of a migrated row |
| mig_valid | output | 1 | Migration request offered |
| mig_ready | input | 1 | Request accepted at this edge when high with mig_valid |
| mig_row | output | ROW_W | Row to migrate |

## Verification
The checks assume that thr_max is at least 1 and is held constant. They also assume that interval_tick is low during reset and that the consumer may stall mig_ready for any length of time. The stimulus sets thr_max once before reset and never changes it. It pulses the tick only between access bursts. It leaves a request unaccepted across long runs of accesses to another row. Threshold values are never read directly. Instead, the bench infers them from how many accesses a fresh row needs before it is requested, using hit-led and conflict-only patterns on each interval.

// File: rtl/rlp_pkg.sv
package rlp_pkg;
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_OFFER = 1'b1
    } req_state_e;
endpackage

// File: rtl/rlp_track.sv
// Tracking table: per-row conflict and access counters, LRU replacement,
// and the promotion decision.
module rlp_track #(
    parameter int ROW_W   = 16,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [ROW_W-1:0] acc_row,
    input  logic             acc_conflict,
    input  logic             allow,
    input  logic [CNT_W-1:0] thr_c,
    input  logic [CNT_W-1:0] thr_a,
    output logic             issue,
    output logic [ROW_W-1:0] issue_row,
    output logic [CNT_W-1:0] issue_conf
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic             vld    [ENTRIES];
    logic [ROW_W-1:0] tag    [ENTRIES];
    logic [CNT_W-1:0] conf_q [ENTRIES];
    logic [CNT_W-1:0] acc_q  [ENTRIES];
    logic [IDX_W-1:0] rank   [ENTRIES];

    logic             hit_any, free_any;
    logic [IDX_W-1:0] hit_idx, free_idx, lru_idx, sel_idx;
    logic [CNT_W-1:0] base_c, base_a, nxt_c, nxt_a;

    always_comb begin
        hit_any  = 1'b0;
        free_any = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        lru_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vld[i] && tag[i] == acc_row) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!vld[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (rank[i] == IDX_W'(ENTRIES - 1)) begin
                lru_idx = IDX_W'(i);
            end
        end
        sel_idx = hit_any ? hit_idx : (free_any ? free_idx : lru_idx);
        base_c  = hit_any ? conf_q[sel_idx] : '0;
        base_a  = hit_any ? acc_q[sel_idx]  : '0;
        nxt_a   = (base_a == CMAX) ? base_a : base_a + 1'b1;
        nxt_c   = (acc_conflict && base_c != CMAX) ? base_c + 1'b1 : base_c;
    end

    assign issue      = acc_valid && allow && (nxt_c > thr_c) && (nxt_a > thr_a);
    assign issue_row  = acc_row;
    assign issue_conf = nxt_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld[i]    <= 1'b0;
                tag[i]    <= '0;
                conf_q[i] <= '0;
                acc_q[i]  <= '0;
                rank[i]   <= IDX_W'(i);
            end
        end else if (acc_valid) begin
            vld[sel_idx]    <= !issue;
            tag[sel_idx]    <= acc_row;
            conf_q[sel_idx] <= nxt_c;
            acc_q[sel_idx]  <= nxt_a;
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == sel_idx) begin
                    rank[i] <= '0;
                end else if (rank[i] < rank[sel_idx]) begin
                    rank[i] <= rank[i] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rlp_tune.sv
// Interval accounting and threshold retuning.
module rlp_tune #(
    parameter int CNT_W  = 4,
    parameter int MC_W   = 8,
    parameter int SUM_W  = 12,
    parameter int COST_W = 8,
    parameter int GAIN_W = 8,
    parameter int INIT_C = 2,
    parameter int INIT_A = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              issue,
    input  logic [CNT_W-1:0]  issue_conf,
    input  logic [CNT_W-1:0]  thr_max,
    input  logic [COST_W-1:0] mig_cost,
    input  logic [GAIN_W-1:0] conflict_gain,
    output logic [CNT_W-1:0]  thr_c,
    output logic [CNT_W-1:0]  thr_a
);
    localparam int CP_W = MC_W + COST_W;
    localparam int BP_W = SUM_W + GAIN_W;
    localparam int PW   = (CP_W > BP_W) ? CP_W : BP_W;

    logic [MC_W-1:0]  mig_n;
    logic [SUM_W-1:0] conf_sum;
    logic [SUM_W:0]   sum_ext;
    logic [PW-1:0]    cost, benefit;
    logic             raise;

    assign cost    = PW'(mig_n) * PW'(mig_cost);
    assign benefit = PW'(conf_sum) * PW'(conflict_gain);
    assign raise   = cost > benefit;
    assign sum_ext = {1'b0, conf_sum} + (SUM_W + 1)'(issue_conf);

    function automatic logic [CNT_W-1:0] retune(input logic [CNT_W-1:0] cur,
                                                input logic up,
                                                input logic [CNT_W-1:0] lim);
        logic [CNT_W-1:0] cand;
        if (up) cand = (cur == {CNT_W{1'b1}}) ? cur : cur + 1'b1;
        else    cand = (cur <= CNT_W'(1)) ? CNT_W'(1) : cur - 1'b1;
        if (cand > lim)      cand = lim;
        if (cand == '0)      cand = CNT_W'(1);
        return cand;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_c    <= CNT_W'(INIT_C);
            thr_a    <= CNT_W'(INIT_A);
            mig_n    <= '0;
            conf_sum <= '0;
        end else if (tick) begin
            thr_c    <= retune(thr_c, raise, thr_max);
            thr_a    <= retune(thr_a, raise, thr_max);
            mig_n    <= issue ? MC_W'(1) : '0;
            conf_sum <= issue ? SUM_W'(issue_conf) : '0;
        end else if (issue) begin
            if (mig_n != {MC_W{1'b1}}) mig_n <= mig_n + 1'b1;
            conf_sum <= sum_ext[SUM_W] ? {SUM_W{1'b1}} : sum_ext[SUM_W-1:0];
        end
    end
endmodule

// File: rtl/rlp_req.sv
// Request handshake state machine.
module rlp_req
    import rlp_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [ROW_W-1:0] issue_row,
    input  logic             mig_ready,
    output logic             allow,
    output logic             mig_valid,
    output logic [ROW_W-1:0] mig_row
);
    req_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     mig_row <= '0;
        else if (issue) mig_row <= issue_row;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (issue)     state_d = S_OFFER;
            S_OFFER: if (mig_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            S_IDLE: begin
                allow     = 1'b1;
                mig_valid = 1'b0;
            end
            S_OFFER: begin
                allow     = 1'b0;
                mig_valid = 1'b1;
            end
            default: begin
                allow     = 1'b0;
                mig_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rowloc_promoter.sv
module rowloc_promoter #(
    parameter int ROW_W   = 16,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 4,
    parameter int MC_W    = 8,
    parameter int SUM_W   = 12,
    parameter int COST_W  = 8,
    parameter int GAIN_W  = 8,
    parameter int INIT_C  = 2,
    parameter int INIT_A  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ROW_W-1:0]  acc_row,
    input  logic              acc_conflict,
    input  logic              interval_tick,
    input  logic [CNT_W-1:0]  thr_max,
    input  logic [COST_W-1:0] mig_cost,
    input  logic [GAIN_W-1:0] conflict_gain,
    output logic              mig_valid,
    input  logic              mig_ready,
    output logic [ROW_W-1:0]  mig_row
);
    logic             issue, allow;
    logic [ROW_W-1:0] issue_row;
    logic [CNT_W-1:0] issue_conf, thr_c, thr_a;

    rlp_track #(.ROW_W(ROW_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) i_track (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_row(acc_row),
        .acc_conflict(acc_conflict), .allow(allow), .thr_c(thr_c), .thr_a(thr_a),
        .issue(issue), .issue_row(issue_row), .issue_conf(issue_conf)
    );

    rlp_tune #(.CNT_W(CNT_W), .MC_W(MC_W), .SUM_W(SUM_W), .COST_W(COST_W),
               .GAIN_W(GAIN_W), .INIT_C(INIT_C), .INIT_A(INIT_A)) i_tune (
        .clk(clk), .rst_n(rst_n), .tick(interval_tick), .issue(issue),
        .issue_conf(issue_conf), .thr_max(thr_max), .mig_cost(mig_cost),
        .conflict_gain(conflict_gain), .thr_c(thr_c), .thr_a(thr_a)
    );

    rlp_req #(.ROW_W(ROW_W)) i_req (
        .clk(clk), .rst_n(rst_n), .issue(issue), .issue_row(issue_row),
        .mig_ready(mig_ready), .allow(allow), .mig_valid(mig_valid), .mig_row(mig_row)
    );
endmodule

// File: rtl/rlp_checker.sv
module rlp_checker #(
    parameter int ROW_W = 16,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mig_valid,
    input logic             mig_ready,
    input logic [ROW_W-1:0] mig_row,
    input logic             issue,
    input logic             interval_tick,
    input logic [CNT_W-1:0] thr_c,
    input logic [CNT_W-1:0] thr_a,
    input logic [CNT_W-1:0] thr_max
);
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mig_valid && !mig_ready) |=> (mig_valid && $stable(mig_row)));

    assert_no_issue_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !mig_valid);

    assert_offer_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mig_valid) |-> $past(issue));

    assert_thr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(interval_tick) |-> (thr_c >= CNT_W'(1) && thr_c <= thr_max &&
                                  thr_a >= CNT_W'(1) && thr_a <= thr_max));

    assert_thr_only_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !interval_tick |=> ($stable(thr_c) && $stable(thr_a)));
endmodule

bind rowloc_promoter rlp_checker #(.ROW_W(ROW_W), .CNT_W(CNT_W)) i_rlp_checker (
    .clk(clk), .rst_n(rst_n), .mig_valid(mig_valid), .mig_ready(mig_ready),
    .mig_row(mig_row), .issue(issue), .interval_tick(interval_tick),
    .thr_c(thr_c), .thr_a(thr_a), .thr_max(thr_max)
);

// File: tb/test_rowloc_promoter.sv
module test_rowloc_promoter;
    localparam int ROW_W = 16;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic [ROW_W-1:0] acc_row = '0;
    logic             acc_conflict = 1'b0;
    logic             interval_tick = 1'b0;
    logic [CNT_W-1:0] thr_max = 4'd5;
    logic [7:0]       mig_cost = 8'd0;
    logic [7:0]       conflict_gain = 8'd1;
    logic             mig_valid;
    logic             mig_ready = 1'b0;
    logic [ROW_W-1:0] mig_row;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    rowloc_promoter i_rowloc_promoter (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_row(acc_row),
        .acc_conflict(acc_conflict), .interval_tick(interval_tick), .thr_max(thr_max),
        .mig_cost(mig_cost), .conflict_gain(conflict_gain), .mig_valid(mig_valid),
        .mig_ready(mig_ready), .mig_row(mig_row)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic acc(input logic [ROW_W-1:0] r, input logic cf);
        @(negedge clk);
        acc_valid = 1'b1; acc_row = r; acc_conflict = cf;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic accept();
        mig_ready = 1'b1;
        @(negedge clk);
        mig_ready = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        interval_tick = 1'b1;
        @(negedge clk);
        interval_tick = 1'b0;
    endtask

    // hits first, then conflicts until a request; returns conflict count
    task automatic probe(input string req, input logic [ROW_W-1:0] r, input int hits,
                         output int n);
        for (int h = 0; h < hits; h++) acc(r, 1'b0);
        n = 0;
        while (!mig_valid && n < 20) begin
            acc(r, 1'b1);
            n++;
        end
        if (mig_valid) begin
            chk(req, "requested row id", int'(mig_row), int'(r));
            accept();
        end
    endtask

    function automatic int adj(input int cur, input bit up, input int lim);
        int c;
        c = up ? ((cur == 15) ? cur : cur + 1) : ((cur <= 1) ? 1 : cur - 1);
        if (c > lim) c = lim;
        if (c < 1) c = 1;
        return c;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n, k, bad, ec, ea, mc, g, cost, ben;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and initial thresholds
        chk("R1", "mig_valid after reset", int'(mig_valid), 0);
        probe("R1", 16'h0100, 0, k);
        chk("R1", "conflict-only accesses to qualify", k, 4);
        probe("R2", 16'h0101, 10, n);
        chk("R2", "conflicts needed after hits", n, 3);

        // R2: entry cleared after request
        probe("R2", 16'h0102, 0, k);
        chk("R2", "first promotion", k, 4);
        acc(16'h0102, 1'b1);
        chk("R2", "no request right after reissue access", int'(mig_valid), 0);
        probe("R2", 16'h0102, 0, n);
        chk("R2", "recount from zero", n, 3);

        // R3: streaming rows stay put
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            acc(16'h0200, 1'b0);
            if (mig_valid) bad++;
        end
        chk("R3", "requests during hit-only stream", bad, 0);
        acc(16'h0200, 1'b1);
        chk("R3", "one conflict after long stream", int'(mig_valid), 0);

        // R4: allocation and LRU replacement
        for (int r = 0; r < 4; r++) begin
            acc(ROW_W'(16'h0300 + r), 1'b1);
            acc(ROW_W'(16'h0300 + r), 1'b1);
        end
        acc(16'h0300, 1'b0);
        acc(16'h0304, 1'b1);
        chk("R4", "no request while filling", int'(mig_valid), 0);
        probe("R4", 16'h0300, 0, n);
        chk("R4", "recently used row kept", n, 1);
        probe("R4", 16'h0301, 0, n);
        chk("R4", "LRU row evicted", n, 4);
        probe("R4", 16'h0302, 0, n);
        chk("R4", "row kept by free-slot choice", n, 2);
        probe("R4", 16'h0303, 0, n);
        chk("R4", "other row kept", n, 2);
        probe("R4", 16'h0304, 0, n);
        chk("R4", "newly allocated row counted", n, 3);

        // R5 and R6: saturation while a request stalls
        for (int i = 0; i < 4; i++) acc(16'h0400, 1'b1);
        chk("R6", "stalled request raised", int'(mig_valid), 1);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            acc(16'h0401, 1'b1);
            if (!mig_valid || mig_row != 16'h0400) bad++;
        end
        chk("R6", "request held stable", bad, 0);
        accept();
        chk("R6", "no automatic request after accept", int'(mig_valid), 0);
        acc(16'h0401, 1'b1);
        chk("R5", "saturated row qualifies", int'(mig_valid), 1);
        chk("R5", "saturated row id", int'(mig_row), 16'h0401);
        accept();

        // R7: flush interval with zero cost -> step down
        ec = 2; ea = 3;
        mig_cost = 8'd0; conflict_gain = 8'd1;
        tick();
        ec = adj(ec, 1'b0, 5); ea = adj(ea, 1'b0, 5);

        // R7 / R8 sweep over intervals
        for (int s = 0; s < 20; s++) begin
            if (s < 10)       begin mc = 100; g = 1; end
            else if (s == 10) begin mc = 18;  g = 3; end
            else if (s == 11) begin mc = 16;  g = 3; end
            else              begin mc = 0;   g = 1; end
            probe("R7", ROW_W'(16'h1000 + 2 * s), 10, n);
            chk((s == 10 || s == 11) ? "R8" : "R7", "conflict threshold probe", n, ec + 1);
            probe("R7", ROW_W'(16'h1001 + 2 * s), 0, k);
            chk((s == 10 || s == 11) ? "R8" : "R7", "joint threshold probe", k,
                ((ec > ea) ? ec : ea) + 1);
            mig_cost = 8'(mc); conflict_gain = 8'(g);
            cost = 2 * mc;
            ben  = ((ec + 1) + (((ec > ea) ? ec : ea) + 1)) * g;
            tick();
            ec = adj(ec, cost > ben, 5);
            ea = adj(ea, cost > ben, 5);
        end
        probe("R7", 16'h2000, 10, n);
        chk("R7", "final conflict threshold", n, ec + 1);
        probe("R7", 16'h2001, 0, k);
        chk("R7", "final joint threshold", k, ((ec > ea) ? ec : ea) + 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule